// File: doc/BRIEF.md
# Execute Stage Integer ALU

This unit produces the execute-stage result for a simple in-order integer pipeline. The decoder hands it the two register read values, the raw 16-bit immediate field, a second-operand selector, a constant shift amount, a flag that says where the shift amount comes from, and a 4-bit operation code. Within the same cycle the unit returns a 32-bit result and a write-cancel flag. The pipeline uses that flag to drop the register write of a conditional move whose condition does not hold.

The second operand of the arithmetic, logic and compare operations is either the second register value or the immediate. The immediate can be extended with its sign or with zeros, so the same selector serves both the sign-extending and the zero-extending immediate instructions. Shifts always act on the second register value. The amount is either the constant field or the low five bits of the first register value. Upper-immediate loads are formed inside the unit. Sums and differences wrap modulo 2^32, and no overflow is flagged anywhere.

Top module: `exalu`

## Requirements
- R1: Code 0 gives rs + B and code 1 gives rs - B, both wrapping modulo 2^32 (for example 0xFFFFFFFF + 1 = 0 and 0 - 1 = 0xFFFFFFFF). B is the selected second operand.
- R2: Codes 2, 3, 4 and 5 give the bitwise AND, OR, XOR and NOR of rs and B.
- R3: The second-operand selector picks B as follows. Value 0 picks rt. Value 1 picks the immediate with bit 15 copied into bits 31..16. Value 2 picks the immediate with bits 31..16 cleared. Value 3 acts like value 0.
- R4: Code 6 gives 1 when rs < B as two's-complement numbers, and 0 otherwise.
- R5: Code 7 gives 1 when rs < B as unsigned numbers, and 0 otherwise. With the sign-extended immediate, 0x8000..0xFFFF compare as 0xFFFF8000..0xFFFFFFFF.
- R6: Codes 8, 9 and 10 shift rt left with zero fill, right with zero fill, and right with sign fill. When the shift-source flag is 0 the amount is the 5-bit constant input. When it is 1 the amount is rs bits 4..0, and rs bits 31..5 are ignored.
- R7: Code 11 gives the immediate in bits 31..16 and zeros in bits 15..0, whatever the values of rs and rt.
- R8: Codes 12 (move-if-nonzero) and 13 (move-if-zero) both give rs as the result. The cancel flag is 1 for code 12 when rt is zero, and for code 13 when rt is non-zero. Otherwise it is 0.
- R9: For every code other than 12 and 13 the cancel flag is 0.
- R10: Codes 14 and 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 16 | Raw immediate field |
| src_sel_i | input | 2 | Second-operand selector |
| shamt_i | input | 5 | Constant shift amount |
| shvar_i | input | 1 | 1: shift amount taken from rs bits 4..0 |
| result_o | output | 32 | Operation result |
| wr_cancel_o | output | 1 | Suppress the register write |

## Verification
The bench puts the compare operations right at the signed and unsigned boundaries: 0x80000000 against 0x7FFFFFFF, and rs against the sign-extended immediates 0x7FFF and 0x8000. A unit that mixes up signed and unsigned ordering, or that zero-extends where it should sign-extend, gives the wrong 0 or 1 there. Every shift amount from 0 to 31 is applied in all three directions and from both amount sources, with random upper bits in rs. This catches a wrong sign fill, a stage wired to the wrong distance, and a variable amount that uses more than five bits. The conditional moves are run with rt at zero and non-zero to catch an inverted or missing cancel, and wrap-around sums show that no overflow handling has crept in.

// File: rtl/exalu_pkg.sv
package exalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_LUI  = 4'd11,
        OP_MOVN = 4'd12,
        OP_MOVZ = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_RT   = 2'd0,
        SRC_SEXT = 2'd1,
        SRC_ZEXT = 2'd2,
        SRC_ALT  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/exalu_opsel.sv
module exalu_opsel
    import exalu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] rt_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [1:0]      sel_i,
    output logic [XLEN-1:0] opb_o
);
    localparam int PADW = XLEN - IMMW;

    always_comb begin
        unique case (src_sel_e'(sel_i))
            SRC_SEXT: opb_o = {{PADW{imm_i[IMMW-1]}}, imm_i};
            SRC_ZEXT: opb_o = {{PADW{1'b0}}, imm_i};
            default:  opb_o = rt_i;
        endcase
    end
endmodule

// File: rtl/exalu_arith.sv
module exalu_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0] wide;

    // one adder serves add, subtract and both compares
    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i ^ {XLEN{sub_i}}} + {{XLEN{1'b0}}, sub_i};
        sum_o  = wide[MSB:0];
        lt_u_o = ~wide[XLEN];
        lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : wide[MSB];
    end
endmodule

// File: rtl/exalu_shift.sv
module exalu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            right_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] res_o
);
    logic [XLEN-1:0] stg [SHW+1];
    logic            fill;

    // left shifts reuse the right shifter on bit-reversed data
    always_comb begin
        fill = arith_i & right_i & val_i[XLEN-1];
        for (int i = 0; i < XLEN; i++) begin
            stg[0][i] = right_i ? val_i[i] : val_i[XLEN-1-i];
        end
    end

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int DIST = 1 << k;
        always_comb begin
            if (amt_i[k]) stg[k+1] = {{DIST{fill}}, stg[k][XLEN-1:DIST]};
            else          stg[k+1] = stg[k];
        end
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            res_o[i] = right_i ? stg[SHW][i] : stg[SHW][XLEN-1-i];
        end
    end
endmodule

// File: rtl/exalu.sv
module exalu
    import exalu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [1:0]      src_sel_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic            shvar_i,
    output logic [XLEN-1:0] result_o,
    output logic            wr_cancel_o
);
    localparam int LOW = XLEN - IMMW;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            cancel;
    } alu_out_t;

    alu_op_e         op;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] sum;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shres;
    logic [SHW-1:0]  amt;
    logic            rt_zero;
    alu_out_t        out_d;

    assign op      = alu_op_e'(op_i);
    assign amt     = shvar_i ? rs_val_i[SHW-1:0] : shamt_i;
    assign rt_zero = (rt_val_i == '0);

    exalu_opsel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
        .rt_i  (rt_val_i),
        .imm_i (imm_i),
        .sel_i (src_sel_i),
        .opb_o (opb)
    );

    exalu_arith #(.XLEN(XLEN)) u_arith (
        .a_i    (rs_val_i),
        .b_i    (opb),
        .sub_i  (op != OP_ADD),
        .sum_o  (sum),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    exalu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .val_i   (rt_val_i),
        .amt_i   (amt),
        .right_i (op != OP_SLL),
        .arith_i (op == OP_SRA),
        .res_o   (shres)
    );

    always_comb begin
        out_d = '0;
        unique case (op)
            OP_ADD, OP_SUB:         out_d.result = sum;
            OP_AND:                 out_d.result = rs_val_i & opb;
            OP_OR:                  out_d.result = rs_val_i | opb;
            OP_XOR:                 out_d.result = rs_val_i ^ opb;
            OP_NOR:                 out_d.result = ~(rs_val_i | opb);
            OP_SLT:                 out_d.result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:                out_d.result = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA: out_d.result = shres;
            OP_LUI:                 out_d.result = {imm_i, {LOW{1'b0}}};
            OP_MOVN: begin
                out_d.result = rs_val_i;
                out_d.cancel = rt_zero;
            end
            OP_MOVZ: begin
                out_d.result = rs_val_i;
                out_d.cancel = ~rt_zero;
            end
            default:                out_d = '0;
        endcase
    end

    assign result_o    = out_d.result;
    assign wr_cancel_o = out_d.cancel;
endmodule

// File: rtl/exalu_chk.sv
module exalu_chk #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [1:0]      src_sel_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic            shvar_i,
    input  logic [XLEN-1:0] result_o,
    input  logic            wr_cancel_o
);
    logic [SHW-1:0] eff_amt;
    logic           is_move;
    logic           is_shift;

    always_comb begin
        eff_amt  = shvar_i ? rs_val_i[SHW-1:0] : shamt_i;
        is_move  = (op_i == 4'd12) || (op_i == 4'd13);
        is_shift = (op_i >= 4'd8) && (op_i <= 4'd10);

        // R9: cancel only ever comes from a conditional move
        if (!is_move)
            a_r9_cancel_only_moves: assert (!wr_cancel_o)
                else $error("cancel raised for op %0d", op_i);

        // R8: moves hand rs through unchanged
        if (is_move)
            a_r8_move_passes_rs: assert (result_o == rs_val_i)
                else $error("move result %h rs %h", result_o, rs_val_i);

        // R4 / R5: compares are strictly boolean
        if (op_i == 4'd6 || op_i == 4'd7)
            a_r4_compare_boolean: assert (result_o[XLEN-1:1] == '0)
                else $error("compare result %h", result_o);

        // R7: upper-immediate layout
        if (op_i == 4'd11)
            a_r7_lui_layout: assert (result_o == {imm_i, {(XLEN-IMMW){1'b0}}})
                else $error("lui result %h", result_o);

        // R6: a zero shift returns rt untouched
        if (is_shift && eff_amt == '0)
            a_r6_zero_shift_identity: assert (result_o == rt_val_i)
                else $error("zero shift result %h rt %h", result_o, rt_val_i);

        // R10: reserved codes give zero
        if (op_i >= 4'd14)
            a_r10_reserved_zero: assert (result_o == '0)
                else $error("reserved code result %h", result_o);
    end
endmodule

bind exalu exalu_chk #(.XLEN(XLEN), .IMMW(IMMW), .SHW(SHW)) u_chk (.*);

// File: tb/tb_exalu.sv
module tb_exalu;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 200000;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [31:0] rs, rt;
    logic [15:0] imm;
    logic [1:0]  sel;
    logic [4:0]  shamt;
    logic        shvar;
    logic [31:0] result;
    logic        cancel;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    exalu dut (
        .op_i(op), .rs_val_i(rs), .rt_val_i(rt), .imm_i(imm),
        .src_sel_i(sel), .shamt_i(shamt), .shvar_i(shvar),
        .result_o(result), .wr_cancel_o(cancel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected<=%0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] pick_b(logic [1:0] s, logic [31:0] t, logic [15:0] i);
        case (s)
            2'd1:    return {{16{i[15]}}, i};
            2'd2:    return {16'h0, i};
            default: return t;
        endcase
    endfunction

    // returns {cancel, result}
    function automatic logic [32:0] model(logic [3:0] o, logic [31:0] a, logic [31:0] t,
                                          logic [15:0] i, logic [1:0] s, logic [4:0] sa,
                                          logic sv);
        logic [31:0] b;
        logic [4:0]  n;
        b = pick_b(s, t, i);
        n = sv ? a[4:0] : sa;
        case (o)
            4'd0:  return {1'b0, a + b};
            4'd1:  return {1'b0, a - b};
            4'd2:  return {1'b0, a & b};
            4'd3:  return {1'b0, a | b};
            4'd4:  return {1'b0, a ^ b};
            4'd5:  return {1'b0, ~(a | b)};
            4'd6:  return {1'b0, 31'd0, ($signed(a) < $signed(b))};
            4'd7:  return {1'b0, 31'd0, (a < b)};
            4'd8:  return {1'b0, t << n};
            4'd9:  return {1'b0, t >> n};
            4'd10: return {1'b0, 32'($signed(t) >>> n)};
            4'd11: return {1'b0, i, 16'h0};
            4'd12: return {(t == 32'd0), a};
            4'd13: return {(t != 32'd0), a};
            default: return 33'd0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0, 4'd1:        return "R1";
            4'd2, 4'd3, 4'd4, 4'd5: return "R2";
            4'd6:              return "R4";
            4'd7:              return "R5";
            4'd8, 4'd9, 4'd10: return "R6";
            4'd11:             return "R7";
            4'd12, 4'd13:      return "R8";
            default:           return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s op=%0d: actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] t, logic [15:0] i,
                         logic [1:0] s, logic [4:0] sa, logic sv, string req = "");
        logic [32:0] e;
        op = o; rs = a; rt = t; imm = i; sel = s; shamt = sa; shvar = sv;
        #(CLK_PERIOD/2);
        e = model(o, a, t, i, s, sa, sv);
        check((req == "") ? req_of(o) : req, result, e[31:0]);
        check((o == 4'd12 || o == 4'd13) ? "R8" : "R9", {31'd0, cancel}, {31'd0, e[32]});
        #(CLK_PERIOD/2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        op = '0; rs = '0; rt = '0; imm = '0; sel = '0; shamt = '0; shvar = 1'b0;
        #(CLK_PERIOD/2);
        check("R1", result, 32'd0);           // idle all-zero add
        check("R9", {31'd0, cancel}, 32'd0);
        #(CLK_PERIOD/2);

        // R1 wrap-around
        apply(4'd0, 32'hFFFFFFFF, 32'd1, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd1, 32'd0, 32'd1, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd0, 32'h7FFFFFFF, 32'd1, 16'h0, 2'd0, 5'd0, 1'b0);
        // R3 operand selection
        apply(4'd0, 32'd100, 32'd5, 16'hFFFF, 2'd1, 5'd0, 1'b0, "R3");
        apply(4'd0, 32'd100, 32'd5, 16'hFFFF, 2'd2, 5'd0, 1'b0, "R3");
        apply(4'd3, 32'd0, 32'h12345678, 16'h8001, 2'd3, 5'd0, 1'b0, "R3");
        apply(4'd2, 32'hFFFFFFFF, 32'd0, 16'h8001, 2'd1, 5'd0, 1'b0, "R3");
        // R2 logic
        apply(4'd5, 32'hF0F0F0F0, 32'h0F0F0000, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd4, 32'hAAAA5555, 32'hFFFF0000, 16'h0, 2'd0, 5'd0, 1'b0);
        // R4 signed boundaries
        apply(4'd6, 32'h80000000, 32'h7FFFFFFF, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd6, 32'h7FFFFFFF, 32'h80000000, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd6, 32'hFFFFFFFF, 32'h0, 16'h0000, 2'd1, 5'd0, 1'b0);
        apply(4'd6, 32'h5, 32'h5, 16'h0, 2'd0, 5'd0, 1'b0);
        // R5 unsigned with sign-extended immediate
        apply(4'd7, 32'hFFFF7FFF, 32'h0, 16'h8000, 2'd1, 5'd0, 1'b0);
        apply(4'd7, 32'hFFFF8000, 32'h0, 16'h8000, 2'd1, 5'd0, 1'b0);
        apply(4'd7, 32'h00007FFE, 32'h0, 16'h7FFF, 2'd1, 5'd0, 1'b0);
        apply(4'd7, 32'h00007FFF, 32'h0, 16'h7FFF, 2'd1, 5'd0, 1'b0);
        apply(4'd7, 32'h7FFFFFFF, 32'h80000000, 16'h0, 2'd0, 5'd0, 1'b0);
        // R6 every amount, both sources, random upper rs bits
        for (int k = 0; k < 32; k++) begin
            for (int d = 8; d <= 10; d++) begin
                apply(4'(d), 32'd0, 32'h9ABCDEF1, 16'h0, 2'd0, 5'(k), 1'b0);
                apply(4'(d), {$urandom() & 32'hFFFFFFE0} | 32'(k), 32'h9ABCDEF1,
                      16'h0, 2'd1, 5'(31 - k), 1'b1);
            end
        end
        // R7
        apply(4'd11, 32'hDEADBEEF, 32'h12345678, 16'hA5C3, 2'd0, 5'd0, 1'b0);
        // R8 both conditions
        apply(4'd12, 32'hCAFEF00D, 32'd0, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd12, 32'hCAFEF00D, 32'd4, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd13, 32'h1234, 32'd0, 16'h0, 2'd0, 5'd0, 1'b0);
        apply(4'd13, 32'h1234, 32'h80000000, 16'h0, 2'd0, 5'd0, 1'b0);
        // R10 reserved codes
        apply(4'd14, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 2'd1, 5'd3, 1'b0);
        apply(4'd15, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 2'd2, 5'd3, 1'b1);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, t;
            a = $urandom();
            t = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom();
            if ($urandom_range(0, 7) == 0) a = 32'h80000000 ^ 32'($urandom_range(0, 1));
            apply(4'($urandom_range(0, 15)), a, t, 16'($urandom()),
                  2'($urandom_range(0, 3)), 5'($urandom()), 1'($urandom()));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule